// File: doc/BRIEF.md
# Dual-Protocol Serial Control Register File

This block is the write-only configuration front end of a mixed-signal audio chip. Settings reach it over one of two serial links that share the same clock and data pins. The first is an I2C slave that only receives. The second is a three-wire link with chip-enable, clock and data lines. Both links write into a single set of control fields. These fields select the stereo line output mode, enable the external key path, and set the two microphone gains, the echo delay, the echo gain, the feedback gain and a group of test bits. The fields come out as plain outputs that steer the analog and echo logic.

The chip-enable pin chooses the link. While chip-enable is low the I2C receiver listens and the three-wire receiver is idle. While chip-enable is high the three-wire receiver shifts bits and the I2C receiver is held idle. Every pin is brought into the block clock domain through a short synchronizer. Start, stop, edges and acknowledge timing are all decided from the synchronized samples.

On both links a write carries a sub-address byte and then a data byte, and the sub-address picks which fields the data byte loads. The I2C link checks the device address, acknowledges each accepted byte, and lets several data bytes follow one sub-address. The three-wire link collects a fixed frame and commits it only when chip-enable is released.

Top module: `ctlrf_top`

## Requirements
- R1: After reset every control field output is zero and sda_oe_o is low.
- R2: With ce_i low, an I2C write whose address byte is 0x38 (seven-bit address 0x1C, write bit 0) is acknowledged. sda_oe_o is high during the ninth SCL pulse after the address byte, after the sub-address byte and after each data byte.
- R3: An I2C address byte other than 0x38 is not acknowledged, and this includes 0x39, the read request. The rest of that transfer up to the next START or STOP changes no field.
- R4: A data byte written to sub-address 0x01 loads line_sel_o from bits 7..5, key_en_o from bit 4 and mic1_gain_o from bits 2..0. Bit 3 is ignored, and fields not addressed keep their values.
- R5: A data byte written to sub-address 0x02 loads mic2_gain_o from bits 6..4 and test_o from bits 3..0.
- R6: A data byte written to sub-address 0x03 loads delay_o from bits 6..4 and echo_gain_o from bits 2..0.
- R7: A data byte written to sub-address 0x04 loads fb_gain_o from bits 6..4. The other bits are ignored.
- R8: A write to any other sub-address is acknowledged and changes no field.
- R9: A repeated START, meaning SDA falls while SCL is high, restarts address reception. A transfer that begins after it is decoded afresh.
- R10: While ce_i is high, SCL and SDA activity causes no I2C acknowledge and no I2C write. The three-wire link samples data on each rising clock while ce_i is high, MSB first: 8 address bits equal to 0xA5, then 8 sub-address bits, then 8 data bits. The frame is committed through the same sub-address map when ce_i falls.
- R11: A three-wire frame whose address differs from 0xA5, or whose bit count is not exactly 24, changes no field when ce_i falls.
- R12: Several data bytes that follow one sub-address in a single I2C write each load that same sub-address, so the last one wins. Every one of them is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip enable; low selects I2C, high frames a three-wire transfer |
| scl_i | input | 1 | Shared serial clock pin |
| sda_i | input | 1 | Shared serial data pin (bus level) |
| sda_oe_o | output | 1 | Pulls SDA low for an acknowledge when high |
| line_sel_o | output | 3 | Line output mode code |
| key_en_o | output | 1 | External key path enable |
| mic1_gain_o | output | 3 | Mic 1 gain code |
| mic2_gain_o | output | 3 | Mic 2 gain code |
| test_o | output | 4 | Test bits |
| delay_o | output | 3 | Echo delay code |
| echo_gain_o | output | 3 | Echo output gain code |
| fb_gain_o | output | 3 | Echo feedback gain code |

## Verification
A receiver whose bit count or state has drifted shows it at the next acknowledge. sda_oe_o then pulses in the wrong SCL period or stays low, and that is visible within one byte time. A wrong latched sub-address, or a three-wire counter that has not cleared, appears as a field that changes, or fails to change, a few clock cycles after the data byte's acknowledge or after ce_i falls. For this reason every transfer is followed by a comparison of the whole field set, and a corruption of fields that were not addressed is caught as well as a missed write.

// File: rtl/ctlrf_pkg.sv
package ctlrf_pkg;
  localparam int BYTE_W  = 8;
  localparam int FIELD_W = 3;
  localparam int TEST_W  = 4;

  typedef struct packed {
    logic [FIELD_W-1:0] line_sel;
    logic               key_en;
    logic [FIELD_W-1:0] mic1;
    logic [FIELD_W-1:0] mic2;
    logic [TEST_W-1:0]  test;
    logic [FIELD_W-1:0] dly;
    logic [FIELD_W-1:0] echo;
    logic [FIELD_W-1:0] fb;
  } ctl_regs_t;

  typedef enum logic [2:0] {
    I_IDLE, I_ADDR, I_SUB, I_DATA, I_ACK, I_SKIP
  } i2c_st_t;

  localparam logic [BYTE_W-1:0] SUB_LINE = 8'h01;
  localparam logic [BYTE_W-1:0] SUB_MIC  = 8'h02;
  localparam logic [BYTE_W-1:0] SUB_DLY  = 8'h03;
  localparam logic [BYTE_W-1:0] SUB_FB   = 8'h04;
endpackage

// File: rtl/ctlrf_pin_sync.sv
module ctlrf_pin_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  localparam int DEPTH = STAGES + 1;

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [DEPTH-1:0] sh_q;
    logic [DEPTH-1:0] sh_d;

    always_comb sh_d = {sh_q[DEPTH-2:0], pin_i[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end

    assign lvl_o[g]  = sh_q[STAGES-1];
    assign rise_o[g] = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_o[g] = ~sh_q[STAGES-1] & sh_q[STAGES];
  end
endmodule

// File: rtl/ctlrf_i2c_rx.sv
module ctlrf_i2c_rx
  import ctlrf_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              scl_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_lvl_i,
  input  logic              sda_rise_i,
  input  logic              sda_fall_i,
  output logic              ack_o,
  output logic              wr_o,
  output logic [BYTE_W-1:0] sub_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};

  i2c_st_t           st_q, st_d, nxt_q, nxt_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d, sub_q, sub_d, dat_q, dat_d;
  logic              ack_q, ack_d, wr_q, wr_d;
  logic              start_c, stop_c, rx_st;

  assign start_c = scl_lvl_i & sda_fall_i;
  assign stop_c  = scl_lvl_i & sda_rise_i;
  assign rx_st   = (st_q == I_ADDR) || (st_q == I_SUB) || (st_q == I_DATA);

  always_comb begin
    st_d  = st_q;
    nxt_d = nxt_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    sub_d = sub_q;
    dat_d = dat_q;
    ack_d = ack_q;
    wr_d  = 1'b0;
    if (!en_i) begin
      st_d  = I_IDLE;
      cnt_d = '0;
      ack_d = 1'b0;
    end else if (start_c) begin
      st_d  = I_ADDR;
      cnt_d = '0;
      ack_d = 1'b0;
    end else if (stop_c) begin
      st_d  = I_IDLE;
      cnt_d = '0;
      ack_d = 1'b0;
    end else begin
      if (scl_rise_i && rx_st && (cnt_q != FULL)) begin
        sh_d  = {sh_q[BYTE_W-2:0], sda_lvl_i};
        cnt_d = cnt_q + 1'b1;
      end
      if (scl_fall_i) begin
        unique case (st_q)
          I_ADDR: if (cnt_q == FULL) begin
            cnt_d = '0;
            if (sh_q == ADDR_WR) begin
              ack_d = 1'b1;
              st_d  = I_ACK;
              nxt_d = I_SUB;
            end else begin
              st_d = I_SKIP;
            end
          end
          I_SUB: if (cnt_q == FULL) begin
            cnt_d = '0;
            sub_d = sh_q;
            ack_d = 1'b1;
            st_d  = I_ACK;
            nxt_d = I_DATA;
          end
          I_DATA: if (cnt_q == FULL) begin
            cnt_d = '0;
            dat_d = sh_q;
            wr_d  = 1'b1;
            ack_d = 1'b1;
            st_d  = I_ACK;
            nxt_d = I_DATA;
          end
          I_ACK: begin
            ack_d = 1'b0;
            st_d  = nxt_q;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= I_IDLE;
      nxt_q <= I_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      sub_q <= '0;
      dat_q <= '0;
      ack_q <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      nxt_q <= nxt_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      sub_q <= sub_d;
      dat_q <= dat_d;
      ack_q <= ack_d;
      wr_q  <= wr_d;
    end
  end

  assign ack_o  = ack_q;
  assign wr_o   = wr_q;
  assign sub_o  = sub_q;
  assign data_o = dat_q;
endmodule

// File: rtl/ctlrf_tw_rx.sv
module ctlrf_tw_rx
  import ctlrf_pkg::*;
#(
  parameter logic [BYTE_W-1:0] TW_ADDR = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_lvl_i,
  input  logic              ce_rise_i,
  input  logic              ce_fall_i,
  input  logic              scl_rise_i,
  input  logic              sda_lvl_i,
  output logic              wr_o,
  output logic [BYTE_W-1:0] sub_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int FRAME_BITS = 3 * BYTE_W;
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] OVER_CNT  = CNT_W'(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (ce_rise_i) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (ce_lvl_i && scl_rise_i) begin
      sh_d = {sh_q[FRAME_BITS-2:0], sda_lvl_i};
      if (cnt_q != OVER_CNT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign wr_o   = ce_fall_i && (cnt_q == FRAME_CNT) &&
                  (sh_q[FRAME_BITS-1 -: BYTE_W] == TW_ADDR);
  assign sub_o  = sh_q[2*BYTE_W-1 -: BYTE_W];
  assign data_o = sh_q[BYTE_W-1:0];
endmodule

// File: rtl/ctlrf_regfile.sv
module ctlrf_regfile
  import ctlrf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] sub_i,
  input  logic [BYTE_W-1:0] data_i,
  output ctl_regs_t         regs_o
);
  ctl_regs_t regs_q, regs_d;

  always_comb begin
    regs_d = regs_q;
    if (wr_i) begin
      unique case (sub_i)
        SUB_LINE: begin
          regs_d.line_sel = data_i[7:5];
          regs_d.key_en   = data_i[4];
          regs_d.mic1     = data_i[2:0];
        end
        SUB_MIC: begin
          regs_d.mic2 = data_i[6:4];
          regs_d.test = data_i[3:0];
        end
        SUB_DLY: begin
          regs_d.dly  = data_i[6:4];
          regs_d.echo = data_i[2:0];
        end
        SUB_FB:  regs_d.fb = data_i[6:4];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_d;
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/ctlrf_top.sv
module ctlrf_top
  import ctlrf_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h1C,
  parameter logic [BYTE_W-1:0] TW_ADDR     = 8'hA5,
  parameter int                SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_i,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic [FIELD_W-1:0] line_sel_o,
  output logic               key_en_o,
  output logic [FIELD_W-1:0] mic1_gain_o,
  output logic [FIELD_W-1:0] mic2_gain_o,
  output logic [TEST_W-1:0]  test_o,
  output logic [FIELD_W-1:0] delay_o,
  output logic [FIELD_W-1:0] echo_gain_o,
  output logic [FIELD_W-1:0] fb_gain_o
);
  localparam int PIN_CE = 2, PIN_SDA = 1, PIN_SCL = 0;

  logic [1:0] rst_sq;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_sn = rst_sq[1];

  logic [2:0] p_lvl, p_rise, p_fall;
  ctlrf_pin_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sn), .pin_i({ce_i, sda_i, scl_i}),
    .lvl_o(p_lvl), .rise_o(p_rise), .fall_o(p_fall)
  );

  logic ce_lvl, scl_fall;
  assign ce_lvl   = p_lvl[PIN_CE];
  assign scl_fall = p_fall[PIN_SCL];

  logic              i2c_wr, tw_wr, wr_any;
  logic [BYTE_W-1:0] i2c_sub, i2c_dat, tw_sub, tw_dat, sub_sel, dat_sel;

  ctlrf_i2c_rx #(.DEV_ADDR(DEV_ADDR)) u_i2c (
    .clk(clk), .rst_n(rst_sn), .en_i(~ce_lvl),
    .scl_lvl_i(p_lvl[PIN_SCL]), .scl_rise_i(p_rise[PIN_SCL]), .scl_fall_i(scl_fall),
    .sda_lvl_i(p_lvl[PIN_SDA]), .sda_rise_i(p_rise[PIN_SDA]), .sda_fall_i(p_fall[PIN_SDA]),
    .ack_o(sda_oe_o), .wr_o(i2c_wr), .sub_o(i2c_sub), .data_o(i2c_dat)
  );

  ctlrf_tw_rx #(.TW_ADDR(TW_ADDR)) u_tw (
    .clk(clk), .rst_n(rst_sn), .ce_lvl_i(ce_lvl),
    .ce_rise_i(p_rise[PIN_CE]), .ce_fall_i(p_fall[PIN_CE]),
    .scl_rise_i(p_rise[PIN_SCL]), .sda_lvl_i(p_lvl[PIN_SDA]),
    .wr_o(tw_wr), .sub_o(tw_sub), .data_o(tw_dat)
  );

  assign wr_any  = tw_wr | i2c_wr;
  assign sub_sel = tw_wr ? tw_sub : i2c_sub;
  assign dat_sel = tw_wr ? tw_dat : i2c_dat;

  ctl_regs_t regs_q;
  ctlrf_regfile u_rf (
    .clk(clk), .rst_n(rst_sn), .wr_i(wr_any),
    .sub_i(sub_sel), .data_i(dat_sel), .regs_o(regs_q)
  );

  assign line_sel_o  = regs_q.line_sel;
  assign key_en_o    = regs_q.key_en;
  assign mic1_gain_o = regs_q.mic1;
  assign mic2_gain_o = regs_q.mic2;
  assign test_o      = regs_q.test;
  assign delay_o     = regs_q.dly;
  assign echo_gain_o = regs_q.echo;
  assign fb_gain_o   = regs_q.fb;
endmodule

// File: rtl/ctlrf_chk.sv
module ctlrf_chk
  import ctlrf_pkg::*;
(
  input logic      clk,
  input logic      rst_sn,
  input logic      ce_lvl,
  input logic      scl_fall,
  input logic      sda_oe,
  input logic      i2c_wr,
  input logic      tw_wr,
  input ctl_regs_t regs
);
  // R10: one cycle after chip enable is seen high, no acknowledge is driven
  p_no_ack_ce_high_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(ce_lvl) |-> !sda_oe);

  // R2: an acknowledge only begins right after an SCL falling edge
  p_ack_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(sda_oe) |-> $past(scl_fall));

  // R11: the two links never write in the same cycle
  p_single_writer_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    !(i2c_wr && tw_wr));

  // R4: fields hold when neither link writes
  p_hold_no_write_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    !(i2c_wr || tw_wr) |=> $stable(regs));

  // R10: a three-wire commit happens with chip enable already low
  p_tw_commit_low_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    tw_wr |-> !ce_lvl);
endmodule

bind ctlrf_top ctlrf_chk u_chk (
  .clk(clk), .rst_sn(rst_sn), .ce_lvl(ce_lvl), .scl_fall(scl_fall),
  .sda_oe(sda_oe_o), .i2c_wr(i2c_wr), .tw_wr(tw_wr), .regs(regs_q)
);

// File: tb/ctlrf_top_tb.sv
module ctlrf_top_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, scl = 1'b1, sda_drv = 1'b1;
  logic sda_oe;
  logic [2:0] line_sel, mic1, mic2, dly, echo, fb;
  logic [3:0] test;
  logic key;
  wire  sda_bus = sda_drv & ~sda_oe;

  int n_chk = 0, n_err = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  ctlrf_top u_dut (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .line_sel_o(line_sel), .key_en_o(key),
    .mic1_gain_o(mic1), .mic2_gain_o(mic2), .test_o(test),
    .delay_o(dly), .echo_gain_o(echo), .fb_gain_o(fb)
  );

  // expected model built from the requirement text
  logic [2:0] e_ls = 0, e_m1 = 0, e_m2 = 0, e_dl = 0, e_ec = 0, e_fb = 0;
  logic [3:0] e_ts = 0;
  logic       e_ky = 0;

  logic [22:0] exp_q[$];
  string       tag_q[$];
  event        ev_chk;

  task automatic apply(input logic [7:0] sub, input logic [7:0] d);
    case (sub)
      8'h01: begin e_ls = d[7:5]; e_ky = d[4]; e_m1 = d[2:0]; end
      8'h02: begin e_m2 = d[6:4]; e_ts = d[3:0]; end
      8'h03: begin e_dl = d[6:4]; e_ec = d[2:0]; end
      8'h04: e_fb = d[6:4];
      default: ;
    endcase
  endtask

  task automatic expect_regs(input string tag);
    repeat (8) @(negedge clk);
    exp_q.push_back({e_ls, e_ky, e_m1, e_m2, e_ts, e_dl, e_ec, e_fb});
    tag_q.push_back(tag);
    -> ev_chk;
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(ev_chk);
      while (exp_q.size() > 0) begin
        logic [22:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {line_sel, key, mic1, mic2, test, dly, echo, fb};
        n_chk++;
        if (a !== e) begin
          n_err++;
          $display("FAIL %s fields actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  task automatic ck_ack(input logic got, input logic want, input string tag);
    n_chk++;
    if (got !== want) begin
      n_err++;
      $display("FAIL %s ack actual=%0b expected=%0b", tag, got, want);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; wait_q();
    scl = 1'b1;     wait_q();
    sda_drv = 1'b0; wait_q();
    scl = 1'b0;     wait_q();
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; wait_q();
    scl = 1'b1;     wait_q();
    sda_drv = 1'b1; wait_q();
  endtask

  task automatic i2c_byte(input logic [7:0] b, input logic want, input string tag);
    logic got;
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wait_q();
      scl = 1'b1;     wait_q();
      scl = 1'b0;
    end
    sda_drv = 1'b1; wait_q();
    scl = 1'b1; repeat (Q/2) @(negedge clk);
    got = sda_oe; repeat (Q/2) @(negedge clk);
    scl = 1'b0; wait_q();
    ck_ack(got, want, tag);
  endtask

  task automatic i2c_write(input logic [7:0] sub, input logic [7:0] d, input string tag);
    i2c_start();
    i2c_byte(8'h38, 1'b1, {tag, " R2 addr"});
    i2c_byte(sub, 1'b1, {tag, " R2 sub"});
    i2c_byte(d, 1'b1, {tag, " R2 data"});
    i2c_stop();
  endtask

  task automatic tw_frame(input logic [23:0] f, input int nbits);
    scl = 1'b0;     wait_q();
    sda_drv = 1'b0; wait_q();
    ce = 1'b1;      wait_q();
    for (int i = 23; i >= 24 - nbits; i--) begin
      sda_drv = f[i]; wait_q();
      scl = 1'b1;     wait_q();
      scl = 1'b0;     wait_q();
    end
    ce = 1'b0;      wait_q();
    scl = 1'b1;     wait_q();
    sda_drv = 1'b1; wait_q();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : driver
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    ck_ack(sda_oe, 1'b0, "R1 reset sda_oe");
    expect_regs("R1 reset");

    i2c_write(8'h01, 8'hB3, "R4"); apply(8'h01, 8'hB3); expect_regs("R4 sub1");
    i2c_write(8'h02, 8'h5A, "R5"); apply(8'h02, 8'h5A); expect_regs("R5 sub2");
    i2c_write(8'h03, 8'hE6, "R6"); apply(8'h03, 8'hE6); expect_regs("R6 sub3");
    i2c_write(8'h04, 8'hBF, "R7"); apply(8'h04, 8'hBF); expect_regs("R7 sub4");

    // R3: read request and foreign address
    i2c_start();
    i2c_byte(8'h39, 1'b0, "R3 read addr");
    i2c_byte(8'h01, 1'b0, "R3 skip sub");
    i2c_byte(8'h00, 1'b0, "R3 skip data");
    i2c_stop();
    i2c_start();
    i2c_byte(8'h3A, 1'b0, "R3 other addr");
    i2c_byte(8'h03, 1'b0, "R3 skip sub2");
    i2c_byte(8'h77, 1'b0, "R3 skip data2");
    i2c_stop();
    expect_regs("R3 ignored");

    // R8: unknown sub-address
    i2c_write(8'h07, 8'hFF, "R8"); expect_regs("R8 unknown sub");

    // R9: repeated start
    i2c_start();
    i2c_byte(8'h38, 1'b1, "R9 addr1");
    i2c_byte(8'h01, 1'b1, "R9 sub1");
    i2c_start();
    i2c_byte(8'h38, 1'b1, "R9 addr2");
    i2c_byte(8'h03, 1'b1, "R9 sub2");
    i2c_byte(8'h25, 1'b1, "R9 data");
    i2c_stop();
    apply(8'h03, 8'h25); expect_regs("R9 restart");

    // R12: several data bytes after one sub-address
    i2c_start();
    i2c_byte(8'h38, 1'b1, "R12 addr");
    i2c_byte(8'h02, 1'b1, "R12 sub");
    i2c_byte(8'h10, 1'b1, "R12 data1");
    i2c_byte(8'h70, 1'b1, "R12 data2");
    i2c_stop();
    apply(8'h02, 8'h70); expect_regs("R12 last wins");

    // R10: I2C traffic with chip enable high is ignored
    ce = 1'b1; wait_q();
    i2c_start();
    i2c_byte(8'h38, 1'b0, "R10 ce high addr");
    i2c_byte(8'h04, 1'b0, "R10 ce high sub");
    i2c_byte(8'h40, 1'b0, "R10 ce high data");
    i2c_stop();
    scl = 1'b0; wait_q();
    ce = 1'b0; wait_q();
    scl = 1'b1; wait_q();
    expect_regs("R10 ce high ignored");

    // R10: three-wire frame
    tw_frame({8'hA5, 8'h01, 8'h48}, 24); apply(8'h01, 8'h48);
    expect_regs("R10 three-wire sub1");
    tw_frame({8'hA5, 8'h04, 8'h40}, 24); apply(8'h04, 8'h40);
    expect_regs("R10 three-wire sub4");

    // R11: wrong address and short frame
    tw_frame({8'hA4, 8'h03, 8'h77}, 24); expect_regs("R11 wrong addr");
    tw_frame({8'hA5, 8'h02, 8'h66}, 23); expect_regs("R11 short frame");

    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule